// File: doc/BRIEF.md
# PHY Management Command Engine

This block runs single register accesses to an external Ethernet PHY over the two-wire management interface, using a clock line (MDC) and a bidirectional data line (MDIO). Software first writes a PHY address, a register address and, for a write, a 16-bit data word into a small register window. It then sets a read or write command bit in a control byte. The engine divides the system clock down to MDC and shifts out a complete management frame. On a read, it releases the data line for the turnaround and data bits and collects the PHY's reply.

When the frame ends, the engine clears the command bit. On a read, it has already placed the captured word in the data register. Software learns that the access is complete by polling the control byte until the command bit reads back as zero. Any command written while a frame is running is dropped.

Top module: `mdio_mgmt_top`

## Requirements
- R1: After reset, the control byte, the data register and both address fields read as zero, MDC is low and the MDIO output enable is low.
- R2: The register window decodes four offsets. Offset 0x6C holds the PHY address in bits 4:0. Offset 0x71 holds the register address in bits 4:0. Offset 0x72 is the 16-bit data register. Offset 0x70 is the control byte, in which bit 6 requests a read and bit 5 requests a write. Unused bits read as zero.
- R3: A write frame is sent MSB first as 64 bits: 32 ones, start 01, opcode 01, the 5-bit PHY address, the 5-bit register address, turnaround 10, and then the 16 data bits.
- R4: A read frame carries opcode 10. The output enable is high for the first 46 bits and low for the last 18 (turnaround and data). The 16 bits sampled at the MDC rising edges of bits 48 to 63 are stored MSB first in the data register.
- R5: While a frame runs, MDC is a divided clock with HALF_DIV system cycles high and HALF_DIV system cycles low. It is low when idle. MDIO changes only when MDC falls.
- R6: A command bit stays set for exactly one frame of 64 MDC periods and then clears by itself.
- R7: A control write made while a frame is in progress is ignored. No second frame follows, and the running frame keeps its type.
- R8: If both command bits are written at once, only the read is performed, and the control byte reads back 0x40.
- R9: A write command leaves the data register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register window byte offset |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven toward the PHY |
| mdio_oe | output | 1 | Output enable for mdio_o |
| mdio_i | input | 1 | Management data from the PHY |

## Verification
A bit counter that slips, or a frame shifter that advances on the wrong MDC edge, shows up at once on the captured frame: header fields land in the wrong positions, and the frame is not exactly 64 MDC rising edges long. Both are checked as soon as each frame ends. A wrong read flag releases the output enable too early or too late, which appears in the per-bit enable mask. A wrong read flag also corrupts the word returned in the data register, which is visible on the first read access. A command flag that clears early, or is re-armed by a late write, appears as a control byte that drops before 64 × 2 × HALF_DIV cycles, or as MDC edges that continue after the byte reads zero.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
    localparam logic [7:0] OFS_PHY  = 8'h6C;
    localparam logic [7:0] OFS_CTRL = 8'h70;
    localparam logic [7:0] OFS_REG  = 8'h71;
    localparam logic [7:0] OFS_DATA = 8'h72;
    localparam int CTRL_RD_BIT = 6;
    localparam int CTRL_WR_BIT = 5;
    localparam int FRAME_BITS  = 64;
    localparam logic [5:0] TA_IDX   = 6'd46;
    localparam logic [5:0] DATA_IDX = 6'd48;
    localparam logic [5:0] LAST_IDX = 6'd63;

    typedef struct packed {
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] data;
        logic        rd;
        logic        wr;
    } win_regs_t;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] CNT_TOP = CW'(HALF_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } div_t;

    div_t div_d, div_q;

    always_comb begin
        div_d    = div_q;
        rise_stb = 1'b0;
        fall_stb = 1'b0;
        if (!run) begin
            div_d.cnt = '0;
            div_d.mdc = 1'b0;
        end else if (div_q.cnt == CNT_TOP) begin
            div_d.cnt = '0;
            div_d.mdc = ~div_q.mdc;
            rise_stb  = ~div_q.mdc;
            fall_stb  = div_q.mdc;
        end else begin
            div_d.cnt = div_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign mdc = div_q.mdc;
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_mgmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        is_read,
    input  logic [4:0]  phy,
    input  logic [4:0]  regad,
    input  logic [15:0] wdata,
    input  logic        rise_stb,
    input  logic        fall_stb,
    input  logic        mdio_i,
    output logic        busy,
    output logic        done,
    output logic [15:0] rdata,
    output logic        mdio_o,
    output logic        mdio_oe
);
    typedef struct packed {
        logic                  busy;
        logic                  rd;
        logic [5:0]            idx;
        logic [FRAME_BITS-1:0] frame;
        logic [15:0]           rdata;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        done  = 1'b0;
        if (!seq_q.busy) begin
            if (start) begin
                seq_d.busy  = 1'b1;
                seq_d.rd    = is_read;
                seq_d.idx   = '0;
                seq_d.rdata = '0;
                seq_d.frame = {{32{1'b1}}, 2'b01,
                               is_read ? 2'b10 : 2'b01,
                               phy, regad,
                               is_read ? 2'b11 : 2'b10,
                               is_read ? 16'hFFFF : wdata};
            end
        end else begin
            if (rise_stb && seq_q.rd && (seq_q.idx >= DATA_IDX))
                seq_d.rdata = {seq_q.rdata[14:0], mdio_i};
            if (fall_stb) begin
                if (seq_q.idx == LAST_IDX) begin
                    seq_d.busy = 1'b0;
                    done       = 1'b1;
                end else begin
                    seq_d.idx   = seq_q.idx + 6'd1;
                    seq_d.frame = {seq_q.frame[FRAME_BITS-2:0], 1'b1};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign busy    = seq_q.busy;
    assign rdata   = seq_q.rdata;
    assign mdio_o  = seq_q.busy ? seq_q.frame[FRAME_BITS-1] : 1'b1;
    assign mdio_oe = seq_q.busy && !(seq_q.rd && (seq_q.idx >= TA_IDX));
endmodule

// File: rtl/mdio_mgmt_top.sv
module mdio_mgmt_top
    import mdio_mgmt_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    input  logic        bus_we,
    output logic [15:0] bus_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    win_regs_t win_d, win_q;
    logic        start;
    logic        start_rd;
    logic        seq_busy;
    logic        seq_done;
    logic [15:0] seq_rdata;
    logic        rise_stb;
    logic        fall_stb;
    logic        cmd_rd;
    logic        cmd_wr;

    always_comb begin
        win_d    = win_q;
        start    = 1'b0;
        start_rd = bus_wdata[CTRL_RD_BIT];
        if (bus_we) begin
            case (bus_addr)
                OFS_PHY:  win_d.phy   = bus_wdata[4:0];
                OFS_REG:  win_d.regad = bus_wdata[4:0];
                OFS_DATA: win_d.data  = bus_wdata;
                OFS_CTRL: begin
                    if (!(win_q.rd || win_q.wr)) begin
                        if (bus_wdata[CTRL_RD_BIT]) begin
                            win_d.rd = 1'b1;
                            start    = 1'b1;
                        end else if (bus_wdata[CTRL_WR_BIT]) begin
                            win_d.wr = 1'b1;
                            start    = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
        if (seq_done) begin
            win_d.rd = 1'b0;
            win_d.wr = 1'b0;
            if (win_q.rd) win_d.data = seq_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    always_comb begin
        case (bus_addr)
            OFS_PHY:  bus_rdata = {11'd0, win_q.phy};
            OFS_REG:  bus_rdata = {11'd0, win_q.regad};
            OFS_DATA: bus_rdata = win_q.data;
            OFS_CTRL: bus_rdata = {9'd0, win_q.rd, win_q.wr, 5'd0};
            default:  bus_rdata = 16'd0;
        endcase
    end

    assign cmd_rd = win_q.rd;
    assign cmd_wr = win_q.wr;

    mdio_clk_div #(.HALF_DIV(HALF_DIV)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (seq_busy),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .is_read  (start_rd),
        .phy      (win_q.phy),
        .regad    (win_q.regad),
        .wdata    (win_q.data),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .mdio_i   (mdio_i),
        .busy     (seq_busy),
        .done     (seq_done),
        .rdata    (seq_rdata),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
    input logic clk,
    input logic rst_n,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe,
    input logic cmd_rd,
    input logic cmd_wr,
    input logic seq_busy,
    input logic seq_done
);
    a_r8_one_cmd_type: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_rd && cmd_wr));

    a_r5_mdc_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_busy |-> !mdc);

    a_r5_mdio_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_busy && $past(seq_busy) && (mdio_o != $past(mdio_o))) |-> $fell(mdc));

    a_r6_cmd_clears_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmd_rd || cmd_wr) && !(cmd_rd || cmd_wr)) |-> $past(seq_done));

    a_r6_cmd_tracks_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rd || cmd_wr) == seq_busy);

    a_r4_oe_released_at_read_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_rd) |-> !$past(mdio_oe));

    a_r7_cmd_stable_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(seq_busy) && seq_busy) |-> ($stable(cmd_rd) && $stable(cmd_wr)));
endmodule

bind mdio_mgmt_top mdio_mgmt_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .cmd_rd   (cmd_rd),
    .cmd_wr   (cmd_wr),
    .seq_busy (seq_busy),
    .seq_done (seq_done)
);

// File: tb/mdio_mgmt_top_test.sv
`timescale 1ns/1ps
module mdio_mgmt_top_test;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [15:0] bus_wdata = 16'h0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    int checks = 0;
    int failures = 0;

    logic [63:0] cap;
    logic [63:0] oe_mask;
    int          rises;
    int          falls;
    int          hi_cnt;
    logic [15:0] resp = 16'h0;

    always #5 clk = ~clk;

    mdio_mgmt_top #(.HALF_DIV(HALF)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY model: bit index equals number of falling edges seen in the frame
    always_comb begin
        if (falls == 47)                      mdio_i = 1'b0;
        else if (falls >= 48 && falls <= 63)  mdio_i = resp[63 - falls];
        else                                  mdio_i = 1'b1;
    end

    always @(posedge mdc) begin
        cap     = {cap[62:0], (mdio_oe ? mdio_o : mdio_i)};
        oe_mask = {oe_mask[62:0], mdio_oe};
        rises   = rises + 1;
    end
    always @(negedge mdc) falls = falls + 1;
    always @(posedge clk) if (mdc) hi_cnt = hi_cnt + 1;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic clear_mon();
        cap = '0; oe_mask = '0; rises = 0; falls = 0; hi_cnt = 0;
    endtask

    task automatic wait_idle(output int cycles);
        logic [15:0] v;
        cycles = 0;
        for (int i = 0; i < 5000; i++) begin
            bus_read(8'h70, v);
            cycles++;
            if (v == 16'h0) break;
        end
    endtask

    task automatic t_reset();
        logic [15:0] v;
        bus_read(8'h70, v); check("R1 ctrl", 64'(v), 64'h0);
        bus_read(8'h72, v); check("R1 data", 64'(v), 64'h0);
        bus_read(8'h6C, v); check("R1 phy", 64'(v), 64'h0);
        check("R1 mdc", 64'(mdc), 64'h0);
        check("R1 oe", 64'(mdio_oe), 64'h0);
    endtask

    task automatic t_regs();
        logic [15:0] v;
        bus_write(8'h6C, 16'hFFE5); bus_read(8'h6C, v); check("R2 phy field", 64'(v), 64'h05);
        bus_write(8'h71, 16'h00F3); bus_read(8'h71, v); check("R2 reg field", 64'(v), 64'h13);
        bus_write(8'h72, 16'hBEEF); bus_read(8'h72, v); check("R2 data reg", 64'(v), 64'hBEEF);
        bus_read(8'h70, v); check("R2 ctrl idle", 64'(v), 64'h0);
    endtask

    task automatic t_write();
        logic [15:0] v;
        int cyc;
        bus_write(8'h6C, 16'h0015);
        bus_write(8'h71, 16'h000A);
        bus_write(8'h72, 16'hA5C3);
        clear_mon();
        bus_write(8'h70, 16'h0020);
        bus_read(8'h70, v); check("R6 wr bit set", 64'(v), 64'h20);
        wait_idle(cyc);
        check("R3 write frame", cap, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h15, 5'h0A, 2'b10, 16'hA5C3});
        check("R3 oe whole frame", oe_mask, {64{1'b1}});
        check("R6 64 mdc periods", 64'(rises), 64'd64);
        check("R5 mdc high time", 64'(hi_cnt), 64'(64 * HALF));
        bus_read(8'h72, v); check("R9 data kept", 64'(v), 64'hA5C3);
        check("R5 mdc low after", 64'(mdc), 64'h0);
    endtask

    task automatic t_read();
        logic [15:0] v;
        int cyc;
        bus_write(8'h6C, 16'h0001);
        bus_write(8'h71, 16'h001F);
        resp = 16'h1234;
        clear_mon();
        bus_write(8'h70, 16'h0040);
        bus_read(8'h70, v); check("R6 rd bit set", 64'(v), 64'h40);
        wait_idle(cyc);
        check("R4 read frame", cap, {32'hFFFF_FFFF, 2'b01, 2'b10, 5'h01, 5'h1F, 2'b10, 16'h1234});
        check("R4 oe mask", oe_mask, {{46{1'b1}}, 18'h0});
        bus_read(8'h72, v); check("R4 read data", 64'(v), 64'h1234);
        resp = 16'h8001;
        clear_mon();
        bus_write(8'h70, 16'h0040);
        wait_idle(cyc);
        bus_read(8'h72, v); check("R4 read data edge bits", 64'(v), 64'h8001);
    endtask

    task automatic t_busy_ignore();
        logic [15:0] v;
        int cyc;
        bus_write(8'h72, 16'h5A5A);
        resp = 16'hFFFF;
        clear_mon();
        bus_write(8'h70, 16'h0020);
        repeat (40 * HALF) @(negedge clk);
        bus_write(8'h70, 16'h0040);
        bus_read(8'h70, v); check("R7 type kept", 64'(v), 64'h20);
        wait_idle(cyc);
        repeat (8 * HALF) @(negedge clk);
        check("R7 no second frame", 64'(rises), 64'd64);
        bus_read(8'h70, v); check("R7 ctrl idle", 64'(v), 64'h0);
        bus_read(8'h72, v); check("R7 data not overwritten", 64'(v), 64'h5A5A);
    endtask

    task automatic t_both();
        logic [15:0] v;
        int cyc;
        resp = 16'hC0DE;
        clear_mon();
        bus_write(8'h70, 16'h0060);
        bus_read(8'h70, v); check("R8 read wins", 64'(v), 64'h40);
        wait_idle(cyc);
        check("R8 opcode read", 64'(cap[29:28]), 64'h2);
        bus_read(8'h72, v); check("R8 read data", 64'(v), 64'hC0DE);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        clear_mon();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_write();
        t_read();
        t_busy_ignore();
        t_both();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule